// File: doc/BRIEF.md
# Selectable-Mode Fixed-Point Rounder

This block narrows a signed two's-complement sample from a wide internal width `IW` to a narrower output width `OW` by discarding the `IW-OW` least significant bits. A build-time parameter picks one of four policies: plain truncation, round-half-up, round-half-away-from-zero, or convergent round-half-to-even. It sits between pipeline stages of a fixed-point datapath such as an FFT. Those stages lose precision at every pass, so the choice of rounding policy controls how much bias and error builds up along the chain. Convergent rounding removes the systematic bias of ties, which keeps the error of a cascade of stages lowest.

Each sample comes with a valid flag. The rounded result and the flag both come out of registers exactly one clock later. When the increment overflows the most positive output code, the result wraps around with no saturation.

Top module: `fx_rounder`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock, and `out_data` presents the rounded value of the sample that was valid one clock earlier.
- R2: While `rst` is sampled high at a clock edge, `out_valid` and `out_data` go to zero, including in the middle of a stream.
- R3: With `MODE`=0 (truncate), `out_data` is bits `[IW-1:IW-OW]` of the input, with no adjustment.
- R4: With `MODE`=1 (half-up), one is added to the kept bits exactly when the most significant discarded bit (bit `IW-OW-1`) is one.
- R5: With `MODE`=2 (half away from zero), a discarded fraction of exactly one half moves the result one step away from zero: up for a non-negative input, and no increment for a negative input (sign bit `IW-1` set). Other fractions round to the nearest value.
- R6: With `MODE`=3 (convergent), an exact-half fraction picks whichever of the two neighbours has its LSB at zero. Other fractions round to the nearest value.
- R7: In every mode, an input whose discarded fraction is below one half (bit `IW-OW-1` zero) gives exactly the kept bits.
- R8: An increment past the most positive `OW`-bit code wraps to the most negative code. Example: with `IW`=8 and `OW`=4, input 0x7F gives 0x8 in modes 1 to 3.
- R9: When `IW`=`OW`+1, the only discarded bit is the half bit. Every input with that bit set is then an exact tie, and all four modes behave as above.
- R10: While `in_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | IW | Wide signed sample |
| out_valid | output | 1 | Valid flag, one clock behind `in_valid` |
| out_data | output | OW | Rounded signed sample |

## Verification
The assertions assume that `rst` is held high for at least one clock before the first sample, that `in_data` carries no unknown bits whenever `in_valid` is high, and that `IW` is larger than `OW`. The bench raises reset before any other activity and drives every input only on falling clock edges, always with fully defined values. It pairs an exhaustive sweep of all 8-bit inputs with a full sweep of a 5-to-4-bit instance, so exact ties, near-ties and both signs reach every mode.

// File: rtl/fx_rounder.sv
module fx_rounder #(
  parameter int IW   = 16,
  parameter int OW   = 12,
  parameter int MODE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [IW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);

  localparam int DW = IW - OW;

  logic [OW-1:0] kept;
  logic          half_bit;
  logic          sign_bit;
  logic          low_zero;
  logic          bump;
  logic [OW-1:0] rounded;

  assign kept     = in_data[IW-1:DW];
  assign half_bit = in_data[DW-1];
  assign sign_bit = in_data[IW-1];

  generate
    if (DW == 1) begin : g_tie_single
      assign low_zero = 1'b1;
    end else begin : g_tie_multi
      assign low_zero = ~|in_data[DW-2:0];
    end
  endgenerate

  generate
    if (MODE == 0) begin : g_trunc
      assign bump = 1'b0;
    end else if (MODE == 1) begin : g_half_up
      assign bump = half_bit;
    end else if (MODE == 2) begin : g_away
      assign bump = half_bit & (~low_zero | ~sign_bit);
    end else begin : g_even
      assign bump = half_bit & (~low_zero | kept[0]);
    end
  endgenerate

  assign rounded = kept + OW'(bump);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= rounded;
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  assert_below_half_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_data[DW-1]) |=> out_data == $past(in_data[IW-1:DW]));
  assert_step_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_data == $past(in_data[IW-1:DW]) ||
                  out_data == OW'($past(in_data[IW-1:DW]) + 1'b1)));

  generate
    if (MODE == 0) begin : g_chk_trunc
      assert_trunc_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_data == $past(in_data[IW-1:DW]));
    end else if (MODE == 1) begin : g_chk_up
      assert_half_up_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[DW-1]) |=> out_data == OW'($past(in_data[IW-1:DW]) + 1'b1));
    end else if (MODE == 2) begin : g_chk_away
      assert_tie_neg_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_bit && low_zero && sign_bit) |=> out_data == $past(in_data[IW-1:DW]));
      assert_tie_pos_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_bit && low_zero && !sign_bit) |=> out_data == OW'($past(in_data[IW-1:DW]) + 1'b1));
    end else begin : g_chk_even
      assert_tie_even_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_bit && low_zero) |=> !out_data[0]);
    end
  endgenerate

endmodule

// File: tb/fx_rounder_tb.sv
`timescale 1ns/1ps
module fx_rounder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [4:0] nar_data = '0;

  logic [3:0] wo [4];
  logic       wv [4];
  logic [3:0] no [4];
  logic       nv [4];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_wide
    fx_rounder #(.IW(8), .OW(4), .MODE(g)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(wv[g]), .out_data(wo[g]));
  end

  for (genvar g = 0; g < 4; g++) begin : g_narrow
    fx_rounder #(.IW(5), .OW(4), .MODE(g)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(nar_data),
      .out_valid(nv[g]), .out_data(no[g]));
  end

  // {input, truncate, half-up, away, even}
  localparam logic [23:0] VEC [16] = '{
    24'h18_1222, 24'h28_2332, 24'hE8_EFEE, 24'hD8_DEDE,
    24'h19_1222, 24'h17_1111, 24'hE9_EFFF, 24'hE7_EEEE,
    24'h78_7888, 24'h7F_7888, 24'h88_8988, 24'h00_0000,
    24'h08_0110, 24'hF8_F0F0, 24'h80_8888, 24'h38_3444
  };

  function automatic string req_of(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int ref_round(int v, int dw, int ow, int m);
    int fl, fr, hf, r;
    fl = v >>> dw;
    fr = v - fl * (1 << dw);
    hf = 1 << (dw - 1);
    case (m)
      0: r = fl;
      1: r = fl + ((fr >= hf) ? 1 : 0);
      2: r = (fr > hf) ? fl + 1 : (fr < hf) ? fl : ((v >= 0) ? fl + 1 : fl);
      default: r = (fr > hf) ? fl + 1 : (fr < hf) ? fl : fl + (fl & 1);
    endcase
    return r & ((1 << ow) - 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] w, input logic [4:0] n);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    nar_data = n;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk("R2", int'(wv[m]), 0);
      chk("R2", int'(wo[m]), 0);
      chk("R2", int'(nv[m]), 0);
    end
    rst = 1'b0;

    // R1: one-cycle latency, nothing before the edge
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h28;
    #1;
    chk("R1", int'(wv[3]), 0);
    chk("R1", int'(wo[1]), 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", int'(wv[3]), 1);
    chk("R1", int'(wo[1]), 3);
    @(negedge clk);
    chk("R1", int'(wv[3]), 0);

    // R10: data held while valid is low
    in_data = 8'h7F;
    @(negedge clk);
    for (int m = 0; m < 4; m++) chk("R10", int'(wo[m]), ref_round(40, 4, 4, m));

    // Table of vectors
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][23:16], 5'd0);
      for (int m = 0; m < 4; m++)
        chk(req_of(m), int'(wo[m]), int'(VEC[i][15-4*m -: 4]));
    end

    // R8: wrap at positive maximum
    apply(8'h7F, 5'h0F);
    for (int m = 1; m < 4; m++) begin
      chk("R8", int'(wo[m]), 8);
      chk("R8", int'(no[m]), 8);
    end

    // Exhaustive sweep against the reference model
    for (int w = 0; w < 256; w++) begin
      apply(w[7:0], w[4:0]);
      for (int m = 0; m < 4; m++) begin
        chk((w[3] == 1'b0) ? "R7" : req_of(m), int'(wo[m]),
            ref_round(int'($signed(w[7:0])), 4, 4, m));
        if (w < 32)
          chk("R9", int'(no[m]), ref_round(int'($signed(w[4:0])), 1, 4, m));
      end
    end

    // R2: reset in mid-stream clears the outputs
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h5C;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk("R2", int'(wv[m]), 0);
      chk("R2", int'(wo[m]), 0);
    end
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule